// File: doc/BRIEF.md
# Interrupt Distributor Control Registers

This block is the register front end of an interrupt distributor. It holds the distributor's group-1 enable, answers reads of a fixed type word and a fixed implementer identification word, and keeps one routing register per shared interrupt. Each routing register stores the 24-bit affinity of the processor that the interrupt should reach. The stored affinities are exposed side by side on one output bus, so that target resolution logic elsewhere can use them.

Software reaches the block over a simple register bus. Each request carries a byte address, a write flag, write data and an access size of 32 or 64 bits. Read data comes back on the cycle after the request. When a write turns the group enable from off to on, the block raises a one-cycle wake pulse so that sleeping processors can re-check for pending work.

There are 32 private interrupt lines ahead of the shared ones. Their routing slots exist in the address map but hold nothing. The upper word of every routing register is reserved, because only three affinity levels are kept.

Top module: `irq_dist_regs`

## Requirements
- R1: A read of the control word (address 0x000) returns bit 1 equal to the group enable, bit 4 and bit 6 always set, and every other bit zero.
- R2: A write to the control word sets the group enable to data bit 1 and changes no other state. A write that turns the enable from 0 to 1 makes `wake_pulse` high for exactly the one cycle after the write edge. A write that leaves it at 1 raises no pulse.
- R3: Bits [4:0] of the type word (address 0x004) equal (NUM_SPI + 32)/32 - 1.
- R4: Bits [23:19] of the type word equal ID_BITS - 1. Bit 17 equals HAS_LPI_SVC. All other bits of the type word are zero.
- R5: The identification word (address 0x008) reads IIDR_VALUE. Writes to the type word and to the identification word change no state.
- R6: The routing register of shared interrupt n (n from 32 to NUM_SPI+31) sits at 0x6000 + 8*n. A 64-bit write, or a 32-bit write to its lower word, stores write data bits [23:0] and drops every higher bit. A read returns the stored affinity in bits [23:0] with all higher bits zero. `route_aff[24*(n-32) +: 24]` shows the stored value.
- R7: The upper word of each routing register (0x6000 + 8*n + 4) reads as zero, and writes to it are ignored.
- R8: Routing slots for interrupts 0 to 31, and slots at or beyond NUM_SPI+32, read as zero and ignore writes.
- R9: A read of address 0xFFE8 returns 0x3B. Any other address that no requirement above maps reads as zero.
- R10: `rsp_rdata` carries the result of a read request in the cycle after that request. After a write, or after a cycle with no request, it is zero. For a 32-bit access bits [63:32] are zero.
- R11: Reset clears the group enable, every routing affinity, `wake_pulse` and `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wide | input | 1 | 1 for a 64-bit access, 0 for 32-bit |
| req_addr | input | 16 | Byte address within the register frame |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, valid the cycle after a read request |
| wake_pulse | output | 1 | One-cycle pulse when the group enable turns on |
| route_aff | output | 24*NUM_SPI | Stored affinity of each shared interrupt, lowest interrupt in the lowest slice |

## Verification
Every result of this block is due one clock edge after the request that causes it. Read data, the wake pulse, the new enable and the new routing affinities all become visible together in the cycle that follows the request edge, and the pulse has dropped again one edge later. The bench drives each request on a falling edge and samples on the next falling edge, which is exactly one rising edge later. It samples the pulse once more on the falling edge after that to confirm that it lasted a single cycle. Checks that something is ignored read the touched location back and compare the whole `route_aff` bus in the cycle after the ignored write.

// File: rtl/irq_dist_regs.sv
module irq_dist_regs #(
  parameter int unsigned NUM_SPI     = 32,
  parameter int unsigned ID_BITS     = 10,
  parameter bit          HAS_LPI_SVC = 1'b0,
  parameter logic [31:0] IIDR_VALUE  = 32'h0200_043B
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_wide,
  input  logic [15:0]             req_addr,
  input  logic [63:0]             req_wdata,
  output logic [63:0]             rsp_rdata,
  output logic                    wake_pulse,
  output logic [NUM_SPI*24-1:0]   route_aff
);

  localparam int unsigned NPRIV   = 32;
  localparam int unsigned TOTAL   = NUM_SPI + NPRIV;
  localparam logic [10:0] TOTAL_W = 11'(TOTAL);
  localparam int EN_BIT  = 1;
  localparam int ARE_BIT = 4;
  localparam int DS_BIT  = 6;
  localparam int LPI_BIT = 17;
  localparam int IDB_LSB = 19;

  logic        en_q;
  logic        wake_q;
  logic [63:0] rdata_q;
  logic [23:0] aff_q [NUM_SPI];
  logic [NUM_SPI-1:0] slot_sel;
  logic [23:0] aff_rd;
  logic [63:0] rd_val;
  logic [31:0] type_word;
  logic [31:0] ctrl_word;

  wire is_rd    = req_valid & ~req_write;
  wire is_wr    = req_valid &  req_write;
  wire hit_ctrl = (req_addr[15:2] == 14'h0000);
  wire hit_type = (req_addr[15:2] == 14'h0001);
  wire hit_iid  = (req_addr[15:2] == 14'h0002);
  wire hit_id2  = (req_addr == 16'hFFE8);

  wire       rt_zone  = (req_addr[15:13] == 3'b011);
  wire [9:0] rt_idx   = req_addr[12:3];
  wire       rt_upper = req_addr[2];
  wire       rt_owned = rt_zone && (rt_idx >= 10'd32) && ({1'b0, rt_idx} < TOTAL_W);

  always_comb begin
    type_word = '0;
    type_word[4:0] = 5'(TOTAL / 32 - 1);
    type_word[IDB_LSB +: 5] = 5'(ID_BITS - 1);
    type_word[LPI_BIT] = HAS_LPI_SVC;
  end

  always_comb begin
    ctrl_word = '0;
    ctrl_word[EN_BIT]  = en_q;
    ctrl_word[ARE_BIT] = 1'b1;
    ctrl_word[DS_BIT]  = 1'b1;
  end

  genvar j;
  generate
    for (j = 0; j < NUM_SPI; j++) begin : g_slot
      assign slot_sel[j] = rt_owned && !rt_upper && (rt_idx == 10'(j + NPRIV));
      always_ff @(posedge clk) begin
        if (!rst_n)                   aff_q[j] <= '0;
        else if (is_wr && slot_sel[j]) aff_q[j] <= req_wdata[23:0];
      end
      assign route_aff[j*24 +: 24] = aff_q[j];
    end
  endgenerate

  always_comb begin
    aff_rd = '0;
    for (int k = 0; k < NUM_SPI; k++)
      if (slot_sel[k]) aff_rd = aff_rd | aff_q[k];
  end

  always_comb begin
    rd_val = '0;
    if (hit_ctrl)      rd_val[31:0] = ctrl_word;
    else if (hit_type) rd_val[31:0] = type_word;
    else if (hit_iid)  rd_val[31:0] = IIDR_VALUE;
    else if (hit_id2)  rd_val[7:0]  = 8'h3B;
    else               rd_val[23:0] = aff_rd;
    if (!req_wide) rd_val[63:32] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      wake_q  <= 1'b0;
      rdata_q <= '0;
    end else begin
      rdata_q <= is_rd ? rd_val : 64'h0;
      wake_q  <= 1'b0;
      if (is_wr && hit_ctrl) begin
        en_q   <= req_wdata[EN_BIT];
        wake_q <= req_wdata[EN_BIT] & ~en_q;
      end
    end
  end

  assign rsp_rdata  = rdata_q;
  assign wake_pulse = wake_q;

  assert_wake_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> (en_q && !$past(en_q)));
  assert_wake_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);
  assert_ctrl_fixed_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && hit_ctrl) |=> (rsp_rdata[ARE_BIT] && rsp_rdata[DS_BIT] && rsp_rdata[EN_BIT] == $past(en_q)));
  assert_ro_write_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && (hit_type || hit_iid)) |=> ($stable(en_q) && $stable(route_aff)));
  assert_upper_word_wi_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && rt_zone && rt_upper) |=> $stable(route_aff));
  assert_private_wi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && rt_zone && rt_idx < 10'd32) |=> $stable(route_aff));
  assert_narrow_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && !req_wide) |=> (rsp_rdata[63:32] == 32'h0));
  assert_idle_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_rd |=> (rsp_rdata == 64'h0));

endmodule

// File: tb/irq_dist_regs_tb.sv
module irq_dist_regs_tb;
  localparam int unsigned NSPI = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata, rsp_rdata2;
  logic wake_pulse, wake_pulse2;
  logic [NSPI*24-1:0] route_aff;
  logic [64*24-1:0] route_aff2;
  logic [NSPI*24-1:0] snap;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  irq_dist_regs #(.NUM_SPI(NSPI)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .wake_pulse(wake_pulse), .route_aff(route_aff));

  irq_dist_regs #(.NUM_SPI(64), .ID_BITS(16), .HAS_LPI_SVC(1'b1)) u_dut_lpi (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata2), .wake_pulse(wake_pulse2), .route_aff(route_aff2));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d cycles expected=done", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d, input logic wide);
    req_valid = 1'b1; req_write = 1'b1; req_wide = wide; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic wide);
    req_valid = 1'b1; req_write = 1'b0; req_wide = wide; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [15:0] rt_addr(input int n);
    return 16'(16'h6000 + 8 * n);
  endfunction

  task automatic t_reset;
    chk("R11 rdata after reset", rsp_rdata, 64'h0);
    chk("R11 wake after reset", {63'h0, wake_pulse}, 64'h0);
    chk("R11 affinities after reset", {40'h0, route_aff[23:0]} | {40'h0, route_aff[NSPI*24-1 -: 24]}, 64'h0);
    rd(16'h0000, 1'b0);
    chk("R11 enable clear after reset (R1 fixed bits)", rsp_rdata, 64'h50);
  endtask

  task automatic t_ctrl;
    wr(16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    chk("R2 wake on turn-on", {63'h0, wake_pulse}, 64'h1);
    chk("R10 rdata zero after write", rsp_rdata, 64'h0);
    @(negedge clk);
    chk("R2 wake lasts one cycle", {63'h0, wake_pulse}, 64'h0);
    rd(16'h0000, 1'b0);
    chk("R1 control read enabled", rsp_rdata, 64'h52);
    wr(16'h0000, 64'h2, 1'b0);
    chk("R2 no wake when already on", {63'h0, wake_pulse}, 64'h0);
    wr(16'h0000, 64'h0, 1'b0);
    chk("R2 no wake on turn-off", {63'h0, wake_pulse}, 64'h0);
    rd(16'h0000, 1'b1);
    chk("R1 control read disabled", rsp_rdata, 64'h50);
    wr(16'h0000, 64'h2, 1'b1);
    chk("R2 wake on second turn-on", {63'h0, wake_pulse}, 64'h1);
  endtask

  task automatic t_type;
    rd(16'h0004, 1'b0);
    chk("R3 R4 type word default", rsp_rdata, 64'h0048_0001);
    chk("R4 type word with LPI support", rsp_rdata2, 64'h007A_0002);
    rd(16'h0008, 1'b0);
    chk("R5 identification word", rsp_rdata, 64'h0200_043B);
    snap = route_aff;
    wr(16'h0004, 64'h0, 1'b0);
    wr(16'h0008, 64'h0, 1'b0);
    rd(16'h0004, 1'b0);
    chk("R5 type word unchanged after write", rsp_rdata, 64'h0048_0001);
    rd(16'h0008, 1'b0);
    chk("R5 identification unchanged after write", rsp_rdata, 64'h0200_043B);
    rd(16'h0000, 1'b0);
    chk("R5 enable unchanged by read-only writes", rsp_rdata, 64'h52);
  endtask

  task automatic t_route;
    wr(rt_addr(32), 64'hDEAD_BEEF_1234_5678, 1'b1);
    chk("R6 route_aff first slot", {40'h0, route_aff[23:0]}, 64'h34_5678);
    rd(rt_addr(32), 1'b1);
    chk("R6 64-bit read keeps 24 bits", rsp_rdata, 64'h34_5678);
    wr(rt_addr(NSPI + 31), 64'hFFAB_CDEF, 1'b0);
    chk("R6 route_aff last slot", {40'h0, route_aff[NSPI*24-1 -: 24]}, 64'hAB_CDEF);
    rd(rt_addr(NSPI + 31), 1'b0);
    chk("R6 32-bit read of last slot", rsp_rdata, 64'hAB_CDEF);
    snap = route_aff;
    wr(rt_addr(40) + 16'd4, 64'hFFFF_FFFF, 1'b0);
    chk("R7 upper word write ignored", {63'h0, route_aff == snap}, 64'h1);
    rd(rt_addr(32) + 16'd4, 1'b0);
    chk("R7 upper word reads zero", rsp_rdata, 64'h0);
    wr(rt_addr(5), 64'h00AA_BBCC, 1'b1);
    chk("R8 private slot write ignored", {63'h0, route_aff == snap}, 64'h1);
    rd(rt_addr(5), 1'b1);
    chk("R8 private slot reads zero", rsp_rdata, 64'h0);
    wr(rt_addr(NSPI + 32), 64'h0011_2233, 1'b1);
    chk("R8 out-of-range slot write ignored", {63'h0, route_aff == snap}, 64'h1);
    rd(rt_addr(NSPI + 32), 1'b1);
    chk("R8 out-of-range slot reads zero", rsp_rdata, 64'h0);
  endtask

  task automatic t_idregs;
    rd(16'hFFE8, 1'b0);
    chk("R9 ID2 register", rsp_rdata, 64'h3B);
    rd(16'hFFEC, 1'b0);
    chk("R9 neighbouring ID register zero", rsp_rdata, 64'h0);
    rd(16'h0100, 1'b1);
    chk("R9 unmapped address zero", rsp_rdata, 64'h0);
    @(negedge clk);
    chk("R10 rdata zero on idle cycle", rsp_rdata, 64'h0);
  endtask

  task automatic t_rereset;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R11 affinity cleared by reset", {40'h0, route_aff[23:0]}, 64'h0);
    rd(16'h0000, 1'b0);
    chk("R11 enable cleared by reset", rsp_rdata, 64'h50);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_ctrl;
    t_type;
    t_route;
    t_idregs;
    t_rereset;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule